// File: doc/BRIEF.md
# Parallel ADC Conversion Controller

This block sequences a parallel-output sampling converter of the successive-approximation kind. It can run at up to 2.5 MS/s. A conversion begins when the block pulls its active-low start line down. The converter then drops its busy line for the length of the conversion and raises it when the conversion is done. The result word and the out-of-range flag change shortly after busy returns high. For that reason the block never reads the word at that moment. It takes the word when busy falls at the start of the next conversion. The word taken at that edge therefore always holds the result of the conversion before.

A start request can come from a one-cycle trigger pulse or from an internal rate divider that fires every `rate_div_i` clock cycles. Each word the block takes is tagged with the index of the conversion it belongs to. It is classified as in range, over range or under range from the out-of-range flag and the sign bit. The word then leaves on a valid/ready stream. The stream obeys back-pressure: while `m_valid_o` is high and `m_ready_i` is low, every stream output stays frozen. If a new word arrives while the held word is still waiting, the new word is discarded and a sticky overflow flag is set.

Timing is counted in system clock cycles from the parameter `CLK_NS`, and every nanosecond figure is rounded up to whole cycles. The busy, data and flag inputs each pass through a two-flop synchronizer. A start that does not see busy return high in time sets a sticky timeout flag, and the block goes back to idle.

Top module: `adc_conv_ctrl`

## Requirements
- R1: After reset, `adc_convst_n_o` is high, `m_valid_o` is low, and both `overflow_o` and `timeout_o` are low.
- R2: A start request, from `trig_i` or from the divider, is accepted only when the block is idle. A request that arrives while the start line is low or during the acquisition gap is dropped, not queued.
- R3: The start line stays low for at least ceil(20 ns / CLK_NS) cycles. It returns high only after the synchronized busy line is high again, and never while a conversion is running.
- R4: Between the start line returning high and its next falling edge, at least ceil(100 ns / CLK_NS) clock cycles pass.
- R5: The word is taken on the synchronized falling edge of busy and carries the previous conversion's result. `m_tag_o` is the 0-based index, modulo 2^TAG_W, of the conversion that produced it. The first word after reset has `m_void_o` = 1 and a tag of all ones. All later words have `m_void_o` = 0.
- R6: `m_range_o` decodes as follows. It is 0 (in range) when the flag is 0. It is 1 (over range) when the flag is 1 and the MSB, bit DATA_W-1, is 0. It is 2 (under range) when the flag is 1 and the MSB is 1.
- R7: While `m_valid_o` is high and `m_ready_i` is low, `m_valid_o` and the data, range, tag and void outputs hold their values. A handshake with no new word clears `m_valid_o` on the next cycle.
- R8: If a new word arrives while `m_valid_o` is high and `m_ready_i` is low, the held word is kept and the new one is dropped. `overflow_o` then goes high and stays high until reset.
- R9: If busy has not returned high within ceil(500 ns / CLK_NS) cycles of a start, `timeout_o` goes high and stays high, the start line is released, and the block returns to idle. No word is produced if busy never fell.
- R10: While `auto_en_i` is high and `rate_div_i` is nonzero, the divider requests a start every `rate_div_i` cycles, measured from when it was enabled. With the divider disabled, no start happens without `trig_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Single-cycle start request |
| auto_en_i | input | 1 | Enables periodic starts from the divider |
| rate_div_i | input | DIV_W | Divider period in clock cycles |
| adc_convst_n_o | output | 1 | Active-low conversion start to the converter |
| adc_busy_i | input | 1 | Converter busy line, low while converting |
| adc_data_i | input | DATA_W | Converter result, two's complement |
| adc_ovr_i | input | 1 | Converter out-of-range flag |
| m_valid_o | output | 1 | Stream word valid |
| m_ready_i | input | 1 | Stream sink ready |
| m_data_o | output | DATA_W | Captured word |
| m_range_o | output | 2 | Range class: 0 in, 1 over, 2 under |
| m_tag_o | output | TAG_W | Index of the conversion that produced the word |
| m_void_o | output | 1 | Word predates the first conversion after reset |
| overflow_o | output | 1 | Sticky: a word was dropped under back-pressure |
| timeout_o | output | 1 | Sticky: busy did not complete in time |

## Verification
The assertions assume a converter that behaves as a converter should. Busy must fall within a few cycles of the start edge and stay low until the conversion is done. The data and flag lines must be steady from shortly after busy rises until the next busy fall, so that the synchronized copies are settled when the word is taken. The bench model meets these rules. It drives busy low 8 ns after the start edge, holds it low for 300 ns, and changes the data only 5 ns after busy rises. The one exception is a dead-converter mode, used only to provoke the timeout. Triggers and ready changes are applied at the falling clock edge, and the bench issues triggers only once it has seen the controller idle, except in the directed tests that exist to show that requests are dropped.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

  typedef enum logic [1:0] {
    RNG_IN    = 2'd0,
    RNG_OVER  = 2'd1,
    RNG_UNDER = 2'd2
  } rng_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_CONV = 2'd2,
    ST_ACQ  = 2'd3
  } seq_st_e;

  // nanoseconds to clock cycles, rounded up, never below one
  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic rng_e classify(input logic flag, input logic msb);
    if (!flag)    return RNG_IN;
    else if (msb) return RNG_UNDER;
    else          return RNG_OVER;
  endfunction

endpackage

// File: rtl/acc_sync.sv
module acc_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      hold_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      hold_q <= meta_q;
    end
  end

  assign q_o = hold_q;
endmodule

// File: rtl/acc_rate_gen.sv
module acc_rate_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [DIV_W-1:0] period_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             last;

  assign last = (cnt_q == period_i - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (!en_i || period_i == '0) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (last) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + DIV_W'(1);
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/acc_seq_fsm.sv
module acc_seq_fsm
  import adc_ctrl_pkg::*;
#(
  parameter int CLK_NS  = 10,
  parameter int STRB_NS = 20,
  parameter int ACQ_NS  = 100,
  parameter int TO_NS   = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic busy_s_i,
  output logic convst_n_o,
  output logic cap_o,
  output logic timeout_o
);
  localparam int STRB_CYC = ns2cyc(STRB_NS, CLK_NS);
  localparam int ACQ_CYC  = ns2cyc(ACQ_NS, CLK_NS);
  localparam int TO_CYC   = ns2cyc(TO_NS, CLK_NS);
  localparam int TW       = $clog2(TO_CYC + 1);
  localparam int AW       = $clog2(ACQ_CYC + 1);

  seq_st_e       st_q;
  logic [TW-1:0] tcnt_q;
  logic [AW-1:0] acnt_q;
  logic          cs_q;
  logic          to_q;
  logic          expired;
  logic          held_min;
  logic [AW-1:0] hi_cnt_q;

  assign expired  = (tcnt_q == TW'(TO_CYC - 1));
  assign held_min = (tcnt_q >= TW'(STRB_CYC - 1));
  assign cap_o    = (st_q == ST_LOW) && !busy_s_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tcnt_q <= '0;
      acnt_q <= '0;
      cs_q   <= 1'b1;
      to_q   <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (req_i) begin
            st_q   <= ST_LOW;
            cs_q   <= 1'b0;
            tcnt_q <= '0;
          end
        end
        ST_LOW: begin
          tcnt_q <= tcnt_q + TW'(1);
          if (!busy_s_i) begin
            st_q <= ST_CONV;
          end else if (expired) begin
            st_q <= ST_IDLE;
            cs_q <= 1'b1;
            to_q <= 1'b1;
          end
        end
        ST_CONV: begin
          tcnt_q <= tcnt_q + TW'(1);
          if (busy_s_i && held_min) begin
            st_q   <= ST_ACQ;
            cs_q   <= 1'b1;
            acnt_q <= '0;
          end else if (expired) begin
            st_q <= ST_IDLE;
            cs_q <= 1'b1;
            to_q <= 1'b1;
          end
        end
        default: begin
          acnt_q <= acnt_q + AW'(1);
          if (acnt_q == AW'(ACQ_CYC - 1)) st_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign convst_n_o = cs_q;
  assign timeout_o  = to_q;

  // cycles the start line has been high, saturating; used by the gap check
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         hi_cnt_q <= AW'(ACQ_CYC);
    else if (!cs_q)                     hi_cnt_q <= '0;
    else if (hi_cnt_q != AW'(ACQ_CYC))  hi_cnt_q <= hi_cnt_q + AW'(1);
  end

  AST_RELEASE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(convst_n_o) |-> $past(busy_s_i)); // R3
  AST_ACQ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(convst_n_o) |-> hi_cnt_q >= AW'(ACQ_CYC)); // R4
  AST_TIMEOUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> convst_n_o); // R9
  AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> timeout_o); // R9
endmodule

// File: rtl/acc_out_stage.sv
module acc_out_stage
  import adc_ctrl_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int TAG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              flag_i,
  output logic              m_valid_o,
  input  logic              m_ready_i,
  output logic [DATA_W-1:0] m_data_o,
  output logic [1:0]        m_range_o,
  output logic [TAG_W-1:0]  m_tag_o,
  output logic              m_void_o,
  output logic              overflow_o
);
  logic [TAG_W-1:0] conv_idx_q;
  logic             seen_q;
  logic             slot_free;
  rng_e             cls;

  assign slot_free = !m_valid_o || m_ready_i;
  assign cls       = classify(flag_i, data_i[DATA_W-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_idx_q <= '0;
      seen_q     <= 1'b0;
    end else if (cap_i) begin
      conv_idx_q <= conv_idx_q + TAG_W'(1);
      seen_q     <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid_o  <= 1'b0;
      m_data_o   <= '0;
      m_range_o  <= RNG_IN;
      m_tag_o    <= '0;
      m_void_o   <= 1'b0;
      overflow_o <= 1'b0;
    end else if (cap_i && slot_free) begin
      m_valid_o <= 1'b1;
      m_data_o  <= data_i;
      m_range_o <= cls;
      m_tag_o   <= conv_idx_q - TAG_W'(1);
      m_void_o  <= !seen_q;
    end else if (cap_i) begin
      overflow_o <= 1'b1;
    end else if (m_valid_o && m_ready_i) begin
      m_valid_o <= 1'b0;
    end
  end

  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid_o && !m_ready_i |=> m_valid_o && $stable(m_data_o) && $stable(m_tag_o)
      && $stable(m_range_o) && $stable(m_void_o)); // R7
  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i && m_valid_o && !m_ready_i |=> overflow_o); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o); // R8
  AST_RANGE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid_o |-> m_range_o != 2'd3); // R6
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adc_ctrl_pkg::*;
#(
  parameter int CLK_NS = 10,
  parameter int DATA_W = 14,
  parameter int TAG_W  = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic              auto_en_i,
  input  logic [DIV_W-1:0]  rate_div_i,
  output logic              adc_convst_n_o,
  input  logic              adc_busy_i,
  input  logic [DATA_W-1:0] adc_data_i,
  input  logic              adc_ovr_i,
  output logic              m_valid_o,
  input  logic              m_ready_i,
  output logic [DATA_W-1:0] m_data_o,
  output logic [1:0]        m_range_o,
  output logic [TAG_W-1:0]  m_tag_o,
  output logic              m_void_o,
  output logic              overflow_o,
  output logic              timeout_o
);
  localparam int PW = DATA_W + 1;

  logic [PW-1:0] word_s;
  logic          busy_s;
  logic          tick;
  logic          cap;

  acc_sync #(.W(PW), .RST_VAL('0)) u_sync_word (
    .clk(clk), .rst_n(rst_n), .d_i({adc_ovr_i, adc_data_i}), .q_o(word_s));

  acc_sync #(.W(1), .RST_VAL(1'b1)) u_sync_busy (
    .clk(clk), .rst_n(rst_n), .d_i(adc_busy_i), .q_o(busy_s));

  acc_rate_gen #(.DIV_W(DIV_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .en_i(auto_en_i), .period_i(rate_div_i), .tick_o(tick));

  acc_seq_fsm #(.CLK_NS(CLK_NS)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_i(trig_i | tick), .busy_s_i(busy_s),
    .convst_n_o(adc_convst_n_o), .cap_o(cap), .timeout_o(timeout_o));

  acc_out_stage #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_out (
    .clk(clk), .rst_n(rst_n), .cap_i(cap),
    .data_i(word_s[DATA_W-1:0]), .flag_i(word_s[DATA_W]),
    .m_valid_o(m_valid_o), .m_ready_i(m_ready_i), .m_data_o(m_data_o),
    .m_range_o(m_range_o), .m_tag_o(m_tag_o), .m_void_o(m_void_o),
    .overflow_o(overflow_o));
endmodule

// File: tb/adc_conv_ctrl_bench.sv
module adc_conv_ctrl_bench;
  localparam int DW = 14;
  localparam int TW = 8;
  localparam int NV = 8;
  // {code, flag, expected range}
  localparam logic [16:0] VEC [0:NV-1] = '{
    {14'h0000, 1'b0, 2'd0}, {14'h1FFF, 1'b0, 2'd0},
    {14'h2000, 1'b1, 2'd2}, {14'h1FFF, 1'b1, 2'd1},
    {14'h3FFF, 1'b0, 2'd0}, {14'h2000, 1'b0, 2'd0},
    {14'h0ABC, 1'b1, 2'd1}, {14'h2ABC, 1'b0, 2'd0}};

  logic clk = 0, rst_n = 0, trig = 0, auto_en = 0, ready = 0;
  logic [15:0] rate = 16'd0;
  logic convst_n, busy_n = 1, ovr = 0;
  logic [DW-1:0] dout = '0;
  logic valid, void_w, ovf, tmo;
  logic [DW-1:0] mdata;
  logic [1:0] mrng;
  logic [TW-1:0] mtag;

  logic [DW-1:0] ain = '0;
  logic ain_ovr = 0, dead = 0;
  int checks = 0, fails = 0, cyc = 0;
  int n_starts = 0, fall_cyc = 0, rise_cyc = 0, low_len = 0, gap = 0;
  logic busy_at_rise = 1, prev_cs = 1;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_conv_ctrl u_adc_conv_ctrl (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .auto_en_i(auto_en), .rate_div_i(rate),
    .adc_convst_n_o(convst_n), .adc_busy_i(busy_n), .adc_data_i(dout), .adc_ovr_i(ovr),
    .m_valid_o(valid), .m_ready_i(ready), .m_data_o(mdata), .m_range_o(mrng),
    .m_tag_o(mtag), .m_void_o(void_w), .overflow_o(ovf), .timeout_o(tmo));

  // behavioural converter
  always @(negedge convst_n) begin
    if (!dead && busy_n) begin
      logic [DW-1:0] s;
      logic so;
      s = ain; so = ain_ovr;
      #8   busy_n = 0;
      #300 busy_n = 1;
      #5   begin dout = s; ovr = so; end
    end
  end

  // start-line monitor
  always @(negedge clk) begin
    if (prev_cs && !convst_n) begin
      n_starts = n_starts + 1; gap = cyc - rise_cyc; fall_cyc = cyc;
    end
    if (!prev_cs && convst_n) begin
      rise_cyc = cyc; low_len = cyc - fall_cyc; busy_at_rise = busy_n;
    end
    prev_cs = convst_n;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_trig();
    @(negedge clk) trig = 1;
    @(negedge clk) trig = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!(convst_n && busy_n)) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  task automatic wait_valid(output bit ok);
    ok = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (valid) begin ok = 1; break; end
    end
  endtask

  task automatic pop();
    @(negedge clk) ready = 1;
    @(negedge clk) ready = 0;
  endtask

  initial begin
    #1_500_000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit ok;
    int s0, c1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(convst_n === 1'b1, "R1 convst", convst_n, 1);
    chk(valid === 1'b0, "R1 valid", valid, 0);
    chk(ovf === 1'b0 && tmo === 1'b0, "R1 flags", {ovf, tmo}, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // table walk: R5 previous-conversion word, R6 range decode, R7 pop
    for (int i = 0; i < NV; i++) begin
      ain = VEC[i][16:3]; ain_ovr = VEC[i][2];
      pulse_trig();
      wait_valid(ok);
      chk(ok, "R5 word appears", ok, 1);
      chk(void_w === (i == 0), "R5 void", void_w, i == 0);
      chk(mtag === TW'(i - 1), "R5 tag", mtag, TW'(i - 1));
      if (i > 0) begin
        chk(mdata === VEC[i-1][16:3], "R5 data", mdata, VEC[i-1][16:3]);
        chk(mrng === VEC[i-1][1:0], "R6 range", mrng, VEC[i-1][1:0]);
      end
      pop();
      chk(valid === 1'b0, "R7 handshake clears", valid, 0);
      wait_idle();
    end

    // R8 overflow: hold old word, drop new
    ain = 14'h1234; ain_ovr = 0;
    pulse_trig(); wait_idle();
    chk(valid && mdata === 14'h2ABC && mtag === 8'd7, "R8 held word", mdata, 14'h2ABC);
    chk(ovf === 1'b0, "R8 no drop yet", ovf, 0);
    pulse_trig(); wait_idle();
    chk(ovf === 1'b1, "R8 overflow set", ovf, 1);
    chk(valid && mdata === 14'h2ABC && mtag === 8'd7, "R7 R8 word kept", mdata, 14'h2ABC);
    pop();
    chk(ovf === 1'b1, "R8 sticky", ovf, 1);
    ready = 1;

    // R2 request during conversion dropped
    wait_idle();
    s0 = n_starts;
    pulse_trig();
    repeat (10) @(negedge clk);
    pulse_trig();
    wait_idle();
    chk(n_starts == s0 + 1, "R2 busy request dropped", n_starts - s0, 1);
    chk(busy_at_rise === 1'b1, "R3 release after busy", busy_at_rise, 1);
    chk(low_len >= 2, "R3 low width", low_len, 2);

    // R4 gap with trigger held high
    @(negedge clk) trig = 1;
    while (n_starts < s0 + 3) @(negedge clk);
    trig = 0;
    chk(gap >= 10, "R4 acquisition gap", gap, 10);
    chk(n_starts == s0 + 3, "R2 held trigger one start per slot", n_starts - s0, 3);
    wait_idle();

    // R10 divider
    s0 = n_starts;
    rate = 16'd60; auto_en = 1;
    while (n_starts < s0 + 1) @(negedge clk);
    c1 = fall_cyc;
    while (n_starts < s0 + 2) @(negedge clk);
    chk(fall_cyc - c1 == 60, "R10 period", fall_cyc - c1, 60);
    auto_en = 0;
    wait_idle();
    s0 = n_starts;
    repeat (200) @(negedge clk);
    chk(n_starts == s0, "R10 disabled", n_starts - s0, 0);
    chk(tmo === 1'b0, "R9 no false timeout", tmo, 0);

    // R9 dead converter
    dead = 1;
    s0 = n_starts;
    pulse_trig();
    repeat (80) @(negedge clk);
    chk(tmo === 1'b1, "R9 timeout set", tmo, 1);
    chk(convst_n === 1'b1, "R9 start released", convst_n, 1);
    chk(n_starts == s0 + 1 && valid === 1'b0, "R9 no word", valid, 0);
    repeat (5) @(negedge clk);
    chk(tmo === 1'b1, "R9 sticky", tmo, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule